// File: doc/BRIEF.md
# Extended-Float to Integer Comparator

This block compares an 80-bit extended-precision floating-point value, taken from the top of a floating-point register stack, with a signed integer operand of either 16 or 32 bits. The integer is widened exactly, with no rounding. The comparison is unordered, so any operand that cannot be ordered yields a dedicated result code rather than a fault. The result appears as four condition flags (C3, C2, C1, C0), an invalid-operand flag and a stack-underflow flag. A compare may optionally be followed by a pop of the register stack. The block then issues a pop command, which marks the top register empty, and returns the incremented top-of-stack pointer.

A compare is started by a one-cycle `valid_i` strobe. Every result is registered and appears on the following clock edge together with a one-cycle `out_valid_o` pulse.

The control is a two-state machine. `ST_IDLE` waits for work. `ST_REPORT` marks the cycle in which a fresh result is on the outputs. The transition `GO_REPORT` (valid strobe seen) leads from either state to `ST_REPORT`. The transition `GO_IDLE` (no strobe) leads from either state to `ST_IDLE`. Flag outputs keep their last values between compares.

The 80-bit operand is laid out as follows:
- bit 79 is the sign;
- bits 78:64 are the exponent, biased by 16383;
- bits 63:0 are the significand, and bit 63 is the explicit integer bit.

Top module: `xfloat_int_cmp`

## Requirements
- R1: For ordered operands, the result code {C3,C2,C0} is 3'b000 when the float is greater than the integer, 3'b001 when it is less, and 3'b100 when the two are equal. The integer is widened exactly, so the extreme values -2^31 and 2^31-1 compare exactly.
- R2: With `wide_i`=0, only `int_i[15:0]` is used, taken as a signed 16-bit value; bits 31:16 have no effect. With `wide_i`=1, all 32 bits are used as a signed value.
- R3: A NaN gives code 3'b111 and raises `invalid_o`. A NaN has an exponent of 15'h7FFF and a nonzero value in bits 62:0.
- R4: An unsupported encoding gives code 3'b111 and raises `invalid_o`. This covers any nonzero exponent with bit 63 clear: unnormals, pseudo-NaNs and pseudo-infinities.
- R5: Infinity compares as ordered and leaves `invalid_o` low. Infinity has an exponent of 15'h7FFF and a significand of 64'h8000_0000_0000_0000. +inf is greater than every integer, and -inf is less than every integer.
- R6: The sign of zero is ignored. Both -0.0 and +0.0 compare equal to integer 0.
- R7: Non-integer and denormal floats compare exactly. For example, 2.5 is greater than 2 and less than 3, and a nonzero denormal is greater than 0 and less than 1.
- R8: With `top_empty_i`=1:
  - `underflow_o` is raised and the code is 3'b111;
  - `invalid_o` stays low;
  - no pop is issued, even if one was requested, and `top_o` equals `top_i`.
- R9: When `pop_req_i`=1 and the top register is not empty, `pop_o` pulses and `top_o` is `top_i`+1, wrapping modulo 8. Without a pop request, `pop_o` stays 0 and `top_o` equals `top_i`.
- R10: `c1_o` is 0 after every compare, whether or not underflow occurred.
- R11: Results appear one clock after `valid_i`, together with a one-cycle `out_valid_o` pulse, and the flags hold their values afterwards. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Start a compare this cycle |
| fp_i | input | 80 | Extended-precision operand (top of stack) |
| int_i | input | 32 | Integer operand |
| wide_i | input | 1 | 1: 32-bit integer, 0: 16-bit integer in bits 15:0 |
| pop_req_i | input | 1 | Pop the stack after the compare |
| top_empty_i | input | 1 | Top register is tagged empty |
| top_i | input | 3 | Current top-of-stack pointer |
| out_valid_o | output | 1 | One-cycle pulse: result is fresh |
| c3_o | output | 1 | Condition flag C3 |
| c2_o | output | 1 | Condition flag C2 |
| c1_o | output | 1 | Condition flag C1 |
| c0_o | output | 1 | Condition flag C0 |
| invalid_o | output | 1 | NaN or unsupported operand |
| underflow_o | output | 1 | Stack underflow |
| pop_o | output | 1 | Pop command: mark top register empty |
| top_o | output | 3 | Top-of-stack pointer after the compare |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent, a 64-bit significand, a 32-bit wide integer with a 16-bit narrow mode, and a 3-bit pointer. These values put the exact extremes of both integer widths within reach, along with pointer wrap from 7 to 0 and exponents from just below 1.0 to beyond 2^32.

The reference model compares in a different way from the RTL. It normalises the integer into extended format and orders the two encodings lexicographically. Random operands are drawn around the integer range, and some floats are built as exact copies of the integer so that equality is hit often.

// File: rtl/xic_pkg.sv
package xic_pkg;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    // Maps a relation to the flag code {C3, C2, C0}
    function automatic logic [2:0] rel_to_code(input rel_e rel);
        logic [2:0] code;
        unique case (rel)
            REL_GT:  code = 3'b000;
            REL_LT:  code = 3'b001;
            REL_EQ:  code = 3'b100;
            default: code = 3'b111;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/xic_classify.sv
module xic_classify #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W+SIG_W:0] fp_i,
    output logic                 sign_o,
    output logic [EXP_W-1:0]     exp_o,
    output logic [SIG_W-1:0]     sig_o,
    output logic                 zero_o,
    output logic                 unord_o
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    logic nan;
    logic unsup;

    assign sign_o = fp_i[EXP_W+SIG_W];
    assign exp_o  = fp_i[EXP_W+SIG_W-1:SIG_W];
    assign sig_o  = fp_i[SIG_W-1:0];

    always_comb begin
        zero_o  = (exp_o == '0) && (sig_o == '0);
        nan     = (exp_o == EXP_MAX) && (sig_o[SIG_W-2:0] != '0);
        unsup   = (exp_o != '0) && !sig_o[SIG_W-1];
        unord_o = nan || unsup;
    end

endmodule

// File: rtl/xic_int_prep.sv
module xic_int_prep #(
    parameter int INT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [INT_W-1:0] int_i,
    input  logic             wide_i,
    output logic             neg_o,
    output logic [INT_W-1:0] mag_o
);
    logic [INT_W-1:0] val;

    generate
        if (NARROW_W < INT_W) begin : g_sel
            always_comb begin
                if (wide_i) val = int_i;
                else        val = {{(INT_W-NARROW_W){int_i[NARROW_W-1]}},
                                  int_i[NARROW_W-1:0]};
            end
        end else begin : g_same
            always_comb val = int_i;
        end
    endgenerate

    always_comb begin
        neg_o = val[INT_W-1];
        mag_o = neg_o ? (~val + 1'b1) : val;
    end

endmodule

// File: rtl/xic_magcmp.sv
module xic_magcmp #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    parameter int INT_W = 32
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic [INT_W-1:0] mag_i,
    output logic             gt_o,
    output logic             lt_o
);
    localparam int BIAS = (1 << (EXP_W-1)) - 1;
    localparam int SH_W = $clog2(SIG_W);

    int               e_unb;
    logic [SH_W-1:0]  sh;
    logic [SIG_W-1:0] ipart;
    logic [SIG_W-1:0] mag_ext;
    logic             frac;
    logic             big;

    always_comb begin
        e_unb   = int'(exp_i) - BIAS;
        mag_ext = SIG_W'(mag_i);
        sh      = '0;
        ipart   = '0;
        frac    = 1'b0;
        big     = 1'b0;
        if (e_unb < 0) begin
            frac = |sig_i;
        end else if (e_unb >= INT_W) begin
            big = 1'b1;
        end else begin
            sh    = SH_W'(SIG_W - 1 - e_unb);
            ipart = sig_i >> sh;
            frac  = |(sig_i & ~({SIG_W{1'b1}} << sh));
        end
        gt_o = big || (ipart > mag_ext) || ((ipart == mag_ext) && frac);
        lt_o = !big && (ipart < mag_ext);
    end

endmodule

// File: rtl/xfloat_int_cmp.sv
module xfloat_int_cmp
    import xic_pkg::*;
#(
    parameter int EXP_W    = 15,
    parameter int SIG_W    = 64,
    parameter int INT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int PTR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [EXP_W+SIG_W:0] fp_i,
    input  logic [INT_W-1:0]     int_i,
    input  logic                 wide_i,
    input  logic                 pop_req_i,
    input  logic                 top_empty_i,
    input  logic [PTR_W-1:0]     top_i,
    output logic                 out_valid_o,
    output logic                 c3_o,
    output logic                 c2_o,
    output logic                 c1_o,
    output logic                 c0_o,
    output logic                 invalid_o,
    output logic                 underflow_o,
    output logic                 pop_o,
    output logic [PTR_W-1:0]     top_o
);
    logic             f_sign;
    logic [EXP_W-1:0] f_exp;
    logic [SIG_W-1:0] f_sig;
    logic             f_zero;
    logic             f_unord;
    logic             i_neg;
    logic [INT_W-1:0] i_mag;
    logic             m_gt;
    logic             m_lt;

    xic_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_classify (
        .fp_i    (fp_i),
        .sign_o  (f_sign),
        .exp_o   (f_exp),
        .sig_o   (f_sig),
        .zero_o  (f_zero),
        .unord_o (f_unord)
    );

    xic_int_prep #(.INT_W(INT_W), .NARROW_W(NARROW_W)) i_int_prep (
        .int_i  (int_i),
        .wide_i (wide_i),
        .neg_o  (i_neg),
        .mag_o  (i_mag)
    );

    xic_magcmp #(.EXP_W(EXP_W), .SIG_W(SIG_W), .INT_W(INT_W)) i_magcmp (
        .exp_i (f_exp),
        .sig_i (f_sig),
        .mag_i (i_mag),
        .gt_o  (m_gt),
        .lt_o  (m_lt)
    );

    // Signed relation
    rel_e rel;
    logic f_neg;
    logic do_pop;

    always_comb begin
        f_neg = f_sign && !f_zero;
        if (top_empty_i || f_unord)        rel = REL_UN;
        else if (f_zero && (i_mag == '0))  rel = REL_EQ;
        else if (f_neg != i_neg)           rel = f_neg ? REL_LT : REL_GT;
        else if (m_gt)                     rel = f_neg ? REL_LT : REL_GT;
        else if (m_lt)                     rel = f_neg ? REL_GT : REL_LT;
        else                               rel = REL_EQ;
        do_pop = pop_req_i && !top_empty_i;
    end

    // State register
    state_e state_q;
    state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = valid_i ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = valid_i ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    logic [2:0]       code_q;
    logic             inv_q;
    logic             uf_q;
    logic             pop_q;
    logic [PTR_W-1:0] top_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            inv_q  <= 1'b0;
            uf_q   <= 1'b0;
            pop_q  <= 1'b0;
            top_q  <= '0;
        end else begin
            pop_q <= valid_i && do_pop;
            if (valid_i) begin
                code_q <= rel_to_code(rel);
                inv_q  <= f_unord && !top_empty_i;
                uf_q   <= top_empty_i;
                top_q  <= do_pop ? top_i + 1'b1 : top_i;
            end
        end
    end

    assign out_valid_o = (state_q == ST_REPORT);
    assign c3_o        = code_q[2];
    assign c2_o        = code_q[1];
    assign c0_o        = code_q[0];
    assign c1_o        = 1'b0;
    assign invalid_o   = inv_q;
    assign underflow_o = uf_q;
    assign pop_o       = pop_q;
    assign top_o       = top_q;

endmodule

// File: rtl/xic_chk.sv
module xic_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic             pop_req_i,
    input logic             top_empty_i,
    input logic [PTR_W-1:0] top_i,
    input logic             out_valid_o,
    input logic             c3_o,
    input logic             c2_o,
    input logic             c1_o,
    input logic             c0_o,
    input logic             invalid_o,
    input logic             underflow_o,
    input logic             pop_o,
    input logic [PTR_W-1:0] top_o
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> out_valid_o); // R11
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !out_valid_o && !pop_o); // R11
    AST_UNDERFLOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && top_empty_i) |=> (underflow_o && c3_o && c2_o && c0_o
                                      && !invalid_o && !pop_o && top_o == $past(top_i))); // R8
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pop_req_i && !top_empty_i) |=> (pop_o && top_o == $past(top_i) + 1'b1)); // R9
    AST_C1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !c1_o); // R10
    AST_INVALID_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && invalid_o) |-> (c3_o && c2_o && c0_o)); // R3
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (!c2_o || (c3_o && c0_o)) && !(c3_o && c0_o && !c2_o)); // R1
endmodule

bind xfloat_int_cmp xic_chk #(.PTR_W(PTR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .pop_req_i   (pop_req_i),
    .top_empty_i (top_empty_i),
    .top_i       (top_i),
    .out_valid_o (out_valid_o),
    .c3_o        (c3_o),
    .c2_o        (c2_o),
    .c1_o        (c1_o),
    .c0_o        (c0_o),
    .invalid_o   (invalid_o),
    .underflow_o (underflow_o),
    .pop_o       (pop_o),
    .top_o       (top_o)
);

// File: tb/test_xfloat_int_cmp.sv
module test_xfloat_int_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [79:0] fp_i = '0;
    logic [31:0] int_i = '0;
    logic        wide_i = 1'b0;
    logic        pop_req_i = 1'b0;
    logic        top_empty_i = 1'b0;
    logic [2:0]  top_i = '0;
    logic        out_valid_o, c3_o, c2_o, c1_o, c0_o;
    logic        invalid_o, underflow_o, pop_o;
    logic [2:0]  top_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    xfloat_int_cmp i_xfloat_int_cmp (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fp_i(fp_i), .int_i(int_i),
        .wide_i(wide_i), .pop_req_i(pop_req_i), .top_empty_i(top_empty_i),
        .top_i(top_i), .out_valid_o(out_valid_o), .c3_o(c3_o), .c2_o(c2_o),
        .c1_o(c1_o), .c0_o(c0_o), .invalid_o(invalid_o), .underflow_o(underflow_o),
        .pop_o(pop_o), .top_o(top_o)
    );

    localparam logic [63:0] ONE_SIG = 64'h8000_0000_0000_0000;

    function automatic logic [79:0] mkfp(input logic s, input logic [14:0] e, input logic [63:0] m);
        return {s, e, m};
    endfunction

    // Builds the exact extended encoding of an integer
    function automatic logic [79:0] int_to_fp(input longint v);
        longint mag;
        int     p;
        if (v == 0) return '0;
        mag = (v < 0) ? -v : v;
        p = 0;
        for (int k = 0; k < 63; k++) if (mag[k]) p = k;
        return {v < 0, 15'(16383 + p), 64'(mag) << (63 - p)};
    endfunction

    function automatic longint int_val(input logic [31:0] iv, input logic w);
        if (w) return longint'($signed(iv));
        return longint'($signed(iv[15:0]));
    endfunction

    // Reference code {C3,C2,C0}
    function automatic logic [2:0] ref_code(input logic [79:0] f, input longint v, input logic emp);
        logic [14:0] e;
        logic [63:0] m;
        logic        fz, fneg, ineg, gt, eq;
        logic [79:0] ie;
        e = f[78:64];
        m = f[63:0];
        if (emp) return 3'b111;
        if ((e == 15'h7FFF && m[62:0] != 0) || (e != 0 && !m[63])) return 3'b111;
        fz = (e == 0) && (m == 0);
        if (fz && v == 0) return 3'b100;
        fneg = f[79] && !fz;
        ineg = v < 0;
        if (fneg != ineg) return fneg ? 3'b001 : 3'b000;
        if (v == 0) begin
            gt = 1'b1; eq = 1'b0;
        end else begin
            ie = int_to_fp(v);
            gt = {e, m} > ie[78:0];
            eq = {e, m} == ie[78:0];
        end
        if (eq) return 3'b100;
        if (gt != fneg) return 3'b000;
        return 3'b001;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_cmp(input string req, input logic [79:0] f, input logic [31:0] iv,
                           input logic w, input logic pr, input logic emp, input logic [2:0] tp);
        logic [2:0] ecode;
        logic       einv, epop;
        logic [14:0] e;
        e = f[78:64];
        ecode = ref_code(f, int_val(iv, w), emp);
        einv  = !emp && ((e == 15'h7FFF && f[62:0] != 0) || (e != 0 && !f[63]));
        epop  = pr && !emp;
        @(negedge clk);
        fp_i = f; int_i = iv; wide_i = w; pop_req_i = pr; top_empty_i = emp; top_i = tp;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk(req, "code", {c3_o, c2_o, c0_o}, ecode);
        chk(req, "invalid", invalid_o, einv);
        chk(req, "underflow", underflow_o, emp);
        chk(emp ? "R8" : "R9", "pop", pop_o, epop);
        chk(emp ? "R8" : "R9", "top", top_o, epop ? 3'(tp + 3'd1) : tp);
        chk("R10", "c1", c1_o, 0);
        chk("R11", "out_valid", out_valid_o, 1);
    endtask

    initial begin
        logic [2:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset flags", {out_valid_o, c3_o, c2_o, c1_o, c0_o, invalid_o, underflow_o, pop_o, top_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cmp("R1", mkfp(0, 15'h3FFF, ONE_SIG), 32'd1, 1, 0, 0, 3'd2);
        run_cmp("R1", int_to_fp(-64'sd2147483648), 32'h8000_0000, 1, 0, 0, 3'd0);
        run_cmp("R1", int_to_fp(64'sd2147483647), 32'h7FFF_FFFF, 1, 0, 0, 3'd0);
        run_cmp("R1", int_to_fp(64'sd2147483647), 32'h8000_0000, 1, 0, 0, 3'd0);
        run_cmp("R2", int_to_fp(-64'sd1), 32'h1234_FFFF, 0, 0, 0, 3'd1);
        run_cmp("R2", int_to_fp(-64'sd1), 32'h1234_FFFF, 1, 0, 0, 3'd1);
        run_cmp("R2", int_to_fp(-64'sd32768), 32'h0000_8000, 0, 0, 0, 3'd1);
        run_cmp("R3", mkfp(0, 15'h7FFF, 64'hC000_0000_0000_0000), 32'd5, 1, 0, 0, 3'd0);
        run_cmp("R3", mkfp(1, 15'h7FFF, 64'h8000_0000_0000_0001), 32'd0, 1, 1, 0, 3'd4);
        run_cmp("R4", mkfp(0, 15'h4000, 64'h4000_0000_0000_0000), 32'd2, 1, 0, 0, 3'd0);
        run_cmp("R4", mkfp(0, 15'h7FFF, 64'h0), 32'd2, 1, 0, 0, 3'd0);
        run_cmp("R5", mkfp(0, 15'h7FFF, ONE_SIG), 32'h7FFF_FFFF, 1, 0, 0, 3'd0);
        run_cmp("R5", mkfp(1, 15'h7FFF, ONE_SIG), 32'h8000_0000, 1, 0, 0, 3'd0);
        run_cmp("R6", mkfp(1, 15'h0, 64'h0), 32'd0, 1, 0, 0, 3'd0);
        run_cmp("R6", mkfp(0, 15'h0, 64'h0), 32'hFFFF_0000, 0, 0, 0, 3'd0);
        run_cmp("R7", mkfp(0, 15'h4000, 64'hA000_0000_0000_0000), 32'd2, 1, 0, 0, 3'd0);
        run_cmp("R7", mkfp(0, 15'h4000, 64'hA000_0000_0000_0000), 32'd3, 1, 0, 0, 3'd0);
        run_cmp("R7", mkfp(1, 15'h4000, 64'hA000_0000_0000_0000), 32'hFFFF_FFFD, 1, 0, 0, 3'd0);
        run_cmp("R7", mkfp(0, 15'h0, 64'h0000_0000_0000_0010), 32'd0, 1, 0, 0, 3'd0);
        run_cmp("R7", mkfp(0, 15'h0, 64'h0000_0000_0000_0010), 32'd1, 1, 0, 0, 3'd0);
        run_cmp("R8", mkfp(0, 15'h3FFF, ONE_SIG), 32'd1, 1, 1, 1, 3'd5);
        run_cmp("R8", mkfp(0, 15'h7FFF, 64'hC000_0000_0000_0000), 32'd1, 1, 0, 1, 3'd3);
        run_cmp("R9", mkfp(0, 15'h3FFF, ONE_SIG), 32'd1, 1, 1, 0, 3'd7);
        run_cmp("R9", mkfp(0, 15'h3FFF, ONE_SIG), 32'd1, 1, 1, 0, 3'd3);

        // R11: the pulse drops and the flags hold
        run_cmp("R11", mkfp(0, 15'h3FFF, ONE_SIG), 32'd2, 1, 1, 0, 3'd6);
        held = {c3_o, c2_o, c0_o};
        @(negedge clk);
        chk("R11", "pulse drop", out_valid_o, 0);
        chk("R11", "flags hold", {c3_o, c2_o, c0_o}, held);
        chk("R9", "pop drop", pop_o, 0);

        // Random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] iv;
            logic        w;
            logic [79:0] f;
            int          kind;
            iv = $urandom();
            w  = $urandom_range(0, 1);
            kind = $urandom_range(0, 9);
            if (kind < 3) begin
                f = int_to_fp(int_val(iv, w));
            end else if (kind < 8) begin
                f = mkfp($urandom_range(0, 1), 15'(16383 - 4 + $urandom_range(0, 40)),
                         {1'b1, 31'($urandom()), 32'($urandom())});
            end else if (kind == 8) begin
                f = int_to_fp(int_val(iv, w) + longint'($urandom_range(0, 2)) - 1);
            end else begin
                f = {16'($urandom()), 32'($urandom()), 32'($urandom())};
            end
            run_cmp("R1", f, iv, w, $urandom_range(0, 1), ($urandom_range(0, 15) == 0), 3'($urandom()));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule